// File: doc/BRIEF.md
# Single-Timeslot Three-Address Teaching Processor

This block is a very small processor that completes one instruction in each clock period. A program counter addresses a four-word program store. The word it selects names two source registers, an operation and a destination register. Both sources are read from a four-entry register bank and passed through a combinational ALU. The result lands in the destination on the rising edge that closes the slot. Besides add and multiply, the instruction set has subtract and compare, which set a zero flag. It also has an unconditional jump, a branch that is taken when the zero flag is set, a small-constant load and a no-op.

The program store is written through a load port while reset is held. The program starts at address 0 on the first rising edge after reset is released. The register contents, the program counter and the zero flag all come out of registers for observation.

Top module: `tslot_cpu`

## Requirements
- R1: While `rst` is high, each rising edge clears the program counter, every register and the zero flag. The program store keeps its contents and accepts writes from the load port.
- R2: The word is 11 bits. Bits 10:8 are the opcode (000 add, 001 multiply, 010 subtract, 011 compare, 100 jump, 101 branch-if-zero, 110 set-constant, 111 no-op). Bits 7:6 are source A, 5:4 source B, 3:2 the destination and 1:0 the target. Add writes the low 8 bits of A+B to the destination at the edge that ends the slot and drops any carry.
- R3: Multiply writes the low 8 bits of A*B to the destination and drops the upper bits of the product.
- R4: The two read ports are independent, so both sources may name the same register. Multiply with A=B=R0 then gives R0*R0.
- R5: Every opcode except jump and branch-if-zero advances the program counter by one, and the count wraps from 3 to 0.
- R6: Jump loads the target field into the program counter and writes no register.
- R7: Branch-if-zero with the zero flag at 1 loads the target field into the program counter and writes no register.
- R8: Branch-if-zero with the zero flag at 0 advances the program counter by one.
- R9: Subtract writes the low 8 bits of A-B to the destination. It sets the zero flag to 1 when that result is 0 and to 0 otherwise.
- R10: Compare sets the zero flag exactly as subtract would and leaves every register unchanged.
- R11: Add, multiply, set-constant, jump, branch-if-zero and no-op leave the zero flag unchanged.
- R12: Set-constant writes bits 7:4 and 1:0 of the word, joined in that order as a 6-bit value and zero-extended, to the destination.
- R13: No-op changes no register and no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| prog_we | input | 1 | Write strobe for the program store |
| prog_addr | input | 2 | Program store entry to write |
| prog_word | input | 11 | Instruction word to write |
| regs_o | output | 32 | Register bank contents, R0 in bits 7:0 up to R3 in bits 31:24 |
| pc_o | output | 2 | Program counter |
| zero_o | output | 1 | Zero flag |

## Verification
Every result of this block is due one rising edge after its slot begins. The register write, the new program counter and the zero flag update all come from the instruction fetched during that slot. A branch therefore sees the flag value left by the compare or subtract of an earlier slot. The scoreboard queues one expected state per executed slot, each tagged with the rule it exercises. The monitor compares the ports on the falling edge after each rising edge, so it always samples a settled state from exactly one slot later. Reset clearing is checked on the falling edge after the first rising edge with reset high.

// File: rtl/tslot_pkg.sv
package tslot_pkg;
  localparam int OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 3'd0,
    OP_MUL  = 3'd1,
    OP_SUB  = 3'd2,
    OP_CP   = 3'd3,
    OP_JMP  = 3'd4,
    OP_BREQ = 3'd5,
    OP_SET  = 3'd6,
    OP_NOP  = 3'd7
  } op_e;
endpackage

// File: rtl/tslot_rom.sv
module tslot_rom #(
  parameter int IW = 11,
  parameter int AW = 2
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [IW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [IW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [IW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/tslot_regbank.sv
module tslot_regbank #(
  parameter int DATA_W = 8,
  parameter int AW     = 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [AW-1:0]                 ra1,
  input  logic [AW-1:0]                 ra2,
  output logic [DATA_W-1:0]             rd1,
  output logic [DATA_W-1:0]             rd2,
  input  logic                          we,
  input  logic [AW-1:0]                 wa,
  input  logic [DATA_W-1:0]             wd,
  output logic [(DATA_W<<AW)-1:0]       view
);
  localparam int NREG = 1 << AW;

  logic [DATA_W-1:0] rf [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) rf[i] <= '0;
    end else if (we) begin
      rf[wa] <= wd;
    end
  end

  assign rd1 = rf[ra1];
  assign rd2 = rf[ra2];

  for (genvar g = 0; g < NREG; g++) begin : g_view
    assign view[g*DATA_W +: DATA_W] = rf[g];
  end
endmodule

// File: rtl/tslot_alu.sv
module tslot_alu
  import tslot_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int IMM_W  = 6
) (
  input  op_e               op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic [IMM_W-1:0]  imm,
  output logic [DATA_W-1:0] y,
  output logic              wr_en,
  output logic              flag_we,
  output logic              flag_val
);
  always_comb begin
    y       = '0;
    wr_en   = 1'b0;
    flag_we = 1'b0;
    unique case (op)
      OP_ADD:  begin y = a + b; wr_en = 1'b1; end
      OP_MUL:  begin y = a * b; wr_en = 1'b1; end
      OP_SUB:  begin y = a - b; wr_en = 1'b1; flag_we = 1'b1; end
      OP_CP:   begin y = a - b; flag_we = 1'b1; end
      OP_SET:  begin y = DATA_W'(imm); wr_en = 1'b1; end
      default: begin y = '0; end
    endcase
    flag_val = (y == '0);
  end
endmodule

// File: rtl/tslot_seq.sv
module tslot_seq
  import tslot_pkg::*;
#(
  parameter int PC_W = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  op_e             op,
  input  logic [PC_W-1:0] target,
  input  logic            flag_we,
  input  logic            flag_val,
  output logic [PC_W-1:0] pc,
  output logic            zflag
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pc    <= '0;
      zflag <= 1'b0;
    end else begin
      if (flag_we) zflag <= flag_val;
      case (op)
        OP_JMP:  pc <= target;
        OP_BREQ: pc <= zflag ? target : pc + 1'b1;
        default: pc <= pc + 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/tslot_cpu.sv
module tslot_cpu
  import tslot_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int REG_AW = 2,
  parameter int PC_W   = 2,
  localparam int IW    = OP_W + 3*REG_AW + PC_W,
  localparam int NREG  = 1 << REG_AW
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     prog_we,
  input  logic [PC_W-1:0]          prog_addr,
  input  logic [IW-1:0]            prog_word,
  output logic [NREG*DATA_W-1:0]   regs_o,
  output logic [PC_W-1:0]          pc_o,
  output logic                     zero_o
);
  localparam int IMM_W = 2*REG_AW + PC_W;

  logic [IW-1:0]     instr;
  op_e               op;
  logic [REG_AW-1:0] ra1, ra2, wa;
  logic [PC_W-1:0]   target;
  logic [IMM_W-1:0]  imm;
  logic [DATA_W-1:0] rd1, rd2, res;
  logic              wr_en, flag_we, flag_val;

  assign op     = op_e'(instr[IW-1 -: OP_W]);
  assign ra1    = instr[IW-OP_W-1 -: REG_AW];
  assign ra2    = instr[IW-OP_W-REG_AW-1 -: REG_AW];
  assign wa     = instr[IW-OP_W-2*REG_AW-1 -: REG_AW];
  assign target = instr[PC_W-1:0];
  assign imm    = {ra1, ra2, target};

  tslot_rom #(.IW(IW), .AW(PC_W)) u_rom (
    .clk(clk), .we(prog_we), .waddr(prog_addr), .wdata(prog_word),
    .raddr(pc_o), .rdata(instr)
  );

  tslot_regbank #(.DATA_W(DATA_W), .AW(REG_AW)) u_rf (
    .clk(clk), .rst(rst), .ra1(ra1), .ra2(ra2), .rd1(rd1), .rd2(rd2),
    .we(wr_en & ~rst), .wa(wa), .wd(res), .view(regs_o)
  );

  tslot_alu #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_alu (
    .op(op), .a(rd1), .b(rd2), .imm(imm), .y(res),
    .wr_en(wr_en), .flag_we(flag_we), .flag_val(flag_val)
  );

  tslot_seq #(.PC_W(PC_W)) u_seq (
    .clk(clk), .rst(rst), .op(op), .target(target),
    .flag_we(flag_we), .flag_val(flag_val), .pc(pc_o), .zflag(zero_o)
  );
endmodule

// File: rtl/tslot_cpu_chk.sv
module tslot_cpu_chk
  import tslot_pkg::*;
#(
  parameter int IW   = 11,
  parameter int PC_W = 2,
  parameter int RV_W = 32
) (
  input logic            clk,
  input logic            rst,
  input logic [IW-1:0]   instr,
  input logic [RV_W-1:0] regs_o,
  input logic [PC_W-1:0] pc_o,
  input logic            zero_o
);
  logic [OP_W-1:0] opc;
  assign opc = instr[IW-1 -: OP_W];

  // R1
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> (pc_o == '0 && !zero_o && regs_o == '0));

  // R5
  pc_step_chk: assert property (@(posedge clk) disable iff (rst)
    (opc != OP_JMP && opc != OP_BREQ) |=> pc_o == $past(pc_o) + 1'b1);

  // R6
  jump_load_chk: assert property (@(posedge clk) disable iff (rst)
    (opc == OP_JMP) |=> (pc_o == $past(instr[PC_W-1:0]) && $stable(regs_o)));

  // R7
  branch_taken_chk: assert property (@(posedge clk) disable iff (rst)
    (opc == OP_BREQ && zero_o) |=> (pc_o == $past(instr[PC_W-1:0]) && $stable(regs_o)));

  // R8
  branch_fall_chk: assert property (@(posedge clk) disable iff (rst)
    (opc == OP_BREQ && !zero_o) |=> pc_o == $past(pc_o) + 1'b1);

  // R10
  compare_nowrite_chk: assert property (@(posedge clk) disable iff (rst)
    (opc == OP_CP) |=> $stable(regs_o));

  // R11
  flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (opc != OP_SUB && opc != OP_CP) |=> $stable(zero_o));

  // R13
  nop_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (opc == OP_NOP) |=> $stable(regs_o));
endmodule

bind tslot_cpu tslot_cpu_chk #(.IW(IW), .PC_W(PC_W), .RV_W(NREG*DATA_W)) u_chk (
  .clk(clk), .rst(rst), .instr(instr), .regs_o(regs_o), .pc_o(pc_o), .zero_o(zero_o)
);

// File: tb/tb_tslot_cpu.sv
`timescale 1ns/1ps
module tb_tslot_cpu;
  typedef struct {
    int          pc;
    bit          z;
    logic [31:0] regs;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        prog_we = 1'b0;
  logic [1:0]  prog_addr = '0;
  logic [10:0] prog_word = '0;
  logic [31:0] regs_o;
  logic [1:0]  pc_o;
  logic        zero_o;

  int checks = 0;
  int errors = 0;
  int pend = 0;
  exp_t q[$];

  always #5 clk = ~clk;

  tslot_cpu dut (
    .clk(clk), .rst(rst), .prog_we(prog_we), .prog_addr(prog_addr),
    .prog_word(prog_word), .regs_o(regs_o), .pc_o(pc_o), .zero_o(zero_o)
  );

  function automatic logic [10:0] mk(int op, int a, int b, int w, int t);
    return {3'(op), 2'(a), 2'(b), 2'(w), 2'(t)};
  endfunction

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // monitor: one expected state per executed slot, sampled on the falling edge
  always @(negedge clk) begin
    if (pend > 0) begin
      exp_t e;
      pend--;
      e = q.pop_front();
      checks++;
      if (pc_o !== 2'(e.pc) || zero_o !== e.z || regs_o !== e.regs) begin
        errors++;
        $display("FAIL %s: pc=%0d z=%0b regs=%h expected pc=%0d z=%0b regs=%h",
                 e.tag, pc_o, zero_o, regs_o, e.pc, e.z, e.regs);
      end
    end
  end

  task automatic check_reset(string tag);
    checks++;
    if (pc_o !== 2'd0 || zero_o !== 1'b0 || regs_o !== 32'h0) begin
      errors++;
      $display("FAIL %s: pc=%0d z=%0b regs=%h expected pc=0 z=0 regs=00000000",
               tag, pc_o, zero_o, regs_o);
    end
  endtask

  // driver: load, model the program, queue expectations, run, reset
  task automatic run_prog(logic [10:0] w0, logic [10:0] w1, logic [10:0] w2,
                          logic [10:0] w3, int n);
    logic [10:0] prog [4];
    int r [4];
    int pc;
    bit z;
    prog[0] = w0; prog[1] = w1; prog[2] = w2; prog[3] = w3;
    rst = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      prog_we = 1'b1; prog_addr = 2'(i); prog_word = prog[i];
    end
    @(negedge clk);
    prog_we = 1'b0;
    check_reset("R1 reset before run");
    for (int i = 0; i < 4; i++) r[i] = 0;
    pc = 0; z = 0;
    for (int s = 0; s < n; s++) begin
      exp_t e;
      int op, a, b, w, t, res;
      op = int'(prog[pc][10:8]); a = int'(prog[pc][7:6]);
      b  = int'(prog[pc][5:4]);  w = int'(prog[pc][3:2]); t = int'(prog[pc][1:0]);
      case (op)
        0: begin r[w] = (r[a] + r[b]) & 255; pc = (pc + 1) % 4; e.tag = "R2 R5 R11 add"; end
        1: begin r[w] = (r[a] * r[b]) & 255; pc = (pc + 1) % 4; e.tag = "R3 R4 R5 R11 mul"; end
        2: begin res = (r[a] - r[b]) & 255; r[w] = res; z = (res == 0);
                 pc = (pc + 1) % 4; e.tag = "R9 R5 sub"; end
        3: begin res = (r[a] - r[b]) & 255; z = (res == 0);
                 pc = (pc + 1) % 4; e.tag = "R10 R5 compare"; end
        4: begin pc = t; e.tag = "R6 R11 jump"; end
        5: begin
             if (z) begin pc = t; e.tag = "R7 R11 branch taken"; end
             else begin pc = (pc + 1) % 4; e.tag = "R8 R11 branch not taken"; end
           end
        6: begin r[w] = (a << 4) | (b << 2) | t; pc = (pc + 1) % 4; e.tag = "R12 R5 R11 set"; end
        default: begin pc = (pc + 1) % 4; e.tag = "R13 R5 nop"; end
      endcase
      e.pc = pc; e.z = z;
      e.regs = {8'(r[3]), 8'(r[2]), 8'(r[1]), 8'(r[0])};
      q.push_back(e);
    end
    rst = 1'b0;
    repeat (n) begin
      @(posedge clk);
      #1 pend++;
    end
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check_reset("R1 reset after run");
  endtask

  initial begin
    repeat (2) @(negedge clk);
    // R4 R2 R3 R12: R0=5, R1=R0*R0, R2=R1+R0 = 30, wrap back to start
    run_prog(mk(6, 0, 1, 0, 1), mk(1, 0, 0, 1, 0), mk(0, 1, 0, 2, 0), mk(7, 3, 3, 3, 3), 6);
    // R2 R3 overflow: 63*63 -> 0x81, 0x81+0x81 -> 0x02
    run_prog(mk(6, 3, 3, 0, 3), mk(1, 0, 0, 1, 0), mk(0, 1, 1, 2, 0), mk(0, 2, 1, 3, 0), 5);
    // R10 R7: compare equal sets flag, branch loops to 0
    run_prog(mk(6, 0, 1, 0, 3), mk(3, 0, 0, 0, 0), mk(5, 0, 0, 0, 0), mk(7, 0, 0, 0, 0), 7);
    // R9 R8 R6: 0-3 = 253, flag clear, branch falls through, jump back to 1
    run_prog(mk(6, 0, 0, 1, 3), mk(2, 0, 1, 2, 0), mk(5, 0, 0, 0, 0), mk(4, 0, 0, 0, 1), 8);
    // R9 zero result, R10 compare unequal clears flag, R11 flag held across set/branch
    run_prog(mk(6, 0, 2, 0, 1), mk(2, 0, 0, 3, 0), mk(3, 0, 3, 0, 0), mk(5, 0, 0, 0, 1), 9);
    report();
  end

  initial begin
    #500us;
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    report();
  end
endmodule